// File: doc/BRIEF.md
# Bus-Mapped ADC Conversion Controller

This block is the digital controller of a multi-channel 12-bit analog input card that sits on a byte-addressed bus as a slave. It claims a 1K byte window in a 64K I/O space. The window is chosen by comparing the address bits above bit 9 with a strap input. Inside the window it holds a control/status byte, an interrupt vector byte, an interrupt level byte, a channel/gain byte and a two-byte conversion result.

A conversion can start in two ways. In random-channel mode, a write to the channel/gain byte starts it. In external-trigger mode, a low pulse on the trigger pin starts it on the edge that ends the pulse. The block drives an abstract converter through a start pulse, a busy input and a 12-bit data input. It stores the raw result and presents it in offset binary or two's complement, as a configuration strap selects. It sets a done flag and can raise an interrupt request when a result arrives.

Top module: `adc_card_ctrl`

## Requirements
- R1: Only a strobe whose address bits [15:10] equal `base_sel` is answered. `bus_ack` pulses in the cycle after the strobe. A strobe outside the window gets no acknowledge and changes no register.
- R2: When `cfg_super_only` is 1, a strobe with `bus_super` 0 gets no acknowledge and changes no register.
- R3: The control byte is at offset 0x081. Its writable bits are: bit0 green indicator, bit1 red indicator, bit2 M0, bit3 M1, bit4 interrupt enable. `led_green` and `led_red` follow bits 0 and 1, with 1 meaning on, and these bits read back unchanged. Reset clears all of them.
- R4: With M1:M0 = 10 (random-channel), a write to the channel/gain byte at 0x085 produces exactly one single-cycle `conv_start` pulse, and `conv_chan_gain` shows the written value.
- R5: With M1:M0 = 01 (external-trigger), a low pulse on `trig_n` that lasts at least TRIG_MIN_CYC clock cycles starts one conversion after its rising edge. A shorter pulse starts none.
- R6: Status bit7 (done) is set when the converter drops busy after a start. Reading the low data byte at 0x087 clears it.
- R7: With `cfg_twos` 0, the high byte at 0x086 reads the upper 4 result bits in its low nibble with zeros above, and 0x087 reads the lower 8 bits.
- R8: With `cfg_twos` 1, the result's MSB is inverted and the 12-bit value is sign-extended into the high byte. For example, 0xFFF reads 0x07/0xFF and 0x000 reads 0xF8/0x00.
- R9: The vector byte at 0x083 drives `irq_vector`, and bits [2:0] of the byte at 0x084 drive `irq_level`. `irq_req` is high exactly while done is set, interrupt enable is 1 and the level is nonzero.
- R10: A start request that arrives while a conversion is in flight is ignored, and status bit5 (overrun) is set. Reading 0x087 clears it. Status bit6 reads 1 while a conversion is in flight.
- R11: In any mode other than random-channel, a write to the channel/gain byte starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_super | input | 1 | Access is supervisor |
| base_sel | input | 6 | Window select, compared with address bits [15:10] |
| cfg_super_only | input | 1 | Answer supervisor accesses only |
| cfg_twos | input | 1 | 1 = two's complement result code |
| bus_ack | output | 1 | Access acknowledge |
| bus_rdata | output | 8 | Read data, valid with ack |
| trig_n | input | 1 | External trigger, active low |
| conv_start | output | 1 | Converter start pulse |
| conv_busy | input | 1 | Converter busy |
| conv_data | input | 12 | Converter result, valid when busy falls |
| conv_chan_gain | output | 8 | Channel/gain byte to the front end |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Interrupt level, 0 = none |
| irq_vector | output | 8 | Interrupt vector |
| led_green | output | 1 | Green indicator |
| led_red | output | 1 | Red indicator |

## Verification
The bench builds the block with TRIG_MIN_CYC = 4, so one trigger pulse of eight cycles and one of two cycles fall on opposite sides of the width limit in only a few cycles. The converter model answers after 20 cycles of busy. That window is long enough for a second channel write to land while a conversion is in flight, and short enough that many conversions, in both output codes, fit in one run.

// File: rtl/adc_card_pkg.sv
package adc_card_pkg;
    localparam logic [9:0] OFS_CTRL = 10'h081;
    localparam logic [9:0] OFS_VEC  = 10'h083;
    localparam logic [9:0] OFS_LVL  = 10'h084;
    localparam logic [9:0] OFS_CHAN = 10'h085;
    localparam logic [9:0] OFS_HI   = 10'h086;
    localparam logic [9:0] OFS_LO   = 10'h087;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_EXT  = 2'b01,
        MODE_RAND = 2'b10,
        MODE_RSV  = 2'b11
    } conv_mode_e;
endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
    parameter int MIN_CYC = 13,
    localparam int CNT_W = $clog2(MIN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n,
    output logic fire
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = trig_n;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (!st_q.s2) begin
            if (st_q.cnt != MIN_V) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        st_d.fire = st_q.s2 && !st_q.prev && (st_q.cnt == MIN_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, cnt: '0, fire: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = st_q.fire;

    // R5: a trigger fires for a single cycle only
    p_fire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              clr,
    input  logic              conv_busy,
    input  logic [DATA_W-1:0] conv_data,
    output logic              conv_start,
    output logic              inflight,
    output logic              done,
    output logic              overrun,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              start;
        logic              inflight;
        logic              busy_prev;
        logic              done;
        logic              ovr;
        logic [DATA_W-1:0] result;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    finish;

    assign finish = st_q.busy_prev && !conv_busy && st_q.inflight;

    always_comb begin
        st_d           = st_q;
        st_d.start     = 1'b0;
        st_d.busy_prev = conv_busy;
        if (clr) begin
            st_d.done = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (finish) begin
            st_d.inflight = 1'b0;
            st_d.done     = 1'b1;
            st_d.result   = conv_data;
        end
        if (start_req) begin
            if (st_q.inflight) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.start    = 1'b1;
                st_d.inflight = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_start = st_q.start;
    assign inflight   = st_q.inflight;
    assign done       = st_q.done;
    assign overrun    = st_q.ovr;
    assign result     = st_q.result;

    // R4: each start is a one-cycle pulse
    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R10: a request during a conversion yields no start and flags overrun
    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && inflight) |=> (!conv_start && overrun));
    // R6: the end of busy after a start sets done
    p_done_on_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done);
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
    parameter int DATA_W = 12,
    localparam int PAD = 16 - DATA_W
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              twos,
    output logic [7:0]        hi_byte,
    output logic [7:0]        lo_byte
);
    logic [DATA_W-1:0] coded;
    logic [15:0]       wide;

    always_comb begin
        coded           = raw;
        coded[DATA_W-1] = raw[DATA_W-1] ^ twos;
        wide            = {{PAD{coded[DATA_W-1] & twos}}, coded};
        hi_byte         = wide[15:8];
        lo_byte         = wide[7:0];
    end

    // R8: in two's complement the top bits of the high byte match the sign
    always_comb begin
        if (twos) a_sign_ext_r8: assert (hi_byte[7] == coded[DATA_W-1]);
    end
endmodule

// File: rtl/adc_card_ctrl.sv
module adc_card_ctrl #(
    parameter int ADDR_W       = 16,
    parameter int WIN_W        = 10,
    parameter int DATA_W       = 12,
    parameter int TRIG_MIN_CYC = 13,
    localparam int BASE_W = ADDR_W - WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_super,
    input  logic [BASE_W-1:0] base_sel,
    input  logic              cfg_super_only,
    input  logic              cfg_twos,
    output logic              bus_ack,
    output logic [7:0]        bus_rdata,
    input  logic              trig_n,
    output logic              conv_start,
    input  logic              conv_busy,
    input  logic [DATA_W-1:0] conv_data,
    output logic [7:0]        conv_chan_gain,
    output logic              irq_req,
    output logic [2:0]        irq_level,
    output logic [7:0]        irq_vector,
    output logic              led_green,
    output logic              led_red
);
    import adc_card_pkg::*;

    typedef struct packed {
        logic       ack;
        logic [7:0] rdata;
        logic       green;
        logic       red;
        conv_mode_e mode;
        logic       ie;
        logic [7:0] vec;
        logic [2:0] lvl;
        logic [7:0] chan;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [9:0]        offset;
    logic              hit, wr_hit, rd_hit;
    logic              trig_fire, start_req, clr;
    logic              inflight, done, overrun;
    logic [DATA_W-1:0] result;
    logic [7:0]        hi_byte, lo_byte;

    assign offset = bus_addr[WIN_W-1:0];
    assign hit    = bus_sel && (bus_addr[ADDR_W-1:WIN_W] == base_sel)
                    && (!cfg_super_only || bus_super);
    assign wr_hit = hit && bus_wr;
    assign rd_hit = hit && !bus_wr;
    assign clr    = rd_hit && (offset == OFS_LO);
    assign start_req = (wr_hit && (offset == OFS_CHAN) && (st_q.mode == MODE_RAND))
                     || (trig_fire && (st_q.mode == MODE_EXT));

    adc_trig_detect #(.MIN_CYC(TRIG_MIN_CYC)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .fire(trig_fire)
    );

    adc_conv_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .clr(clr),
        .conv_busy(conv_busy), .conv_data(conv_data),
        .conv_start(conv_start), .inflight(inflight), .done(done),
        .overrun(overrun), .result(result)
    );

    adc_result_fmt #(.DATA_W(DATA_W)) u_fmt (
        .raw(result), .twos(cfg_twos), .hi_byte(hi_byte), .lo_byte(lo_byte)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ack   = hit;
        st_d.rdata = st_q.rdata;
        if (rd_hit) begin
            unique case (offset)
                OFS_CTRL: st_d.rdata = {done, inflight, overrun, st_q.ie,
                                        st_q.mode, st_q.red, st_q.green};
                OFS_VEC:  st_d.rdata = st_q.vec;
                OFS_LVL:  st_d.rdata = {5'b0, st_q.lvl};
                OFS_CHAN: st_d.rdata = st_q.chan;
                OFS_HI:   st_d.rdata = hi_byte;
                OFS_LO:   st_d.rdata = lo_byte;
                default:  st_d.rdata = 8'h00;
            endcase
        end
        if (wr_hit) begin
            unique case (offset)
                OFS_CTRL: begin
                    st_d.green = bus_wdata[0];
                    st_d.red   = bus_wdata[1];
                    st_d.mode  = conv_mode_e'(bus_wdata[3:2]);
                    st_d.ie    = bus_wdata[4];
                end
                OFS_VEC:  st_d.vec  = bus_wdata;
                OFS_LVL:  st_d.lvl  = bus_wdata[2:0];
                OFS_CHAN: st_d.chan = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ack        = st_q.ack;
    assign bus_rdata      = st_q.rdata;
    assign conv_chan_gain = st_q.chan;
    assign led_green      = st_q.green;
    assign led_red        = st_q.red;
    assign irq_vector     = st_q.vec;
    assign irq_level      = st_q.lvl;
    assign irq_req        = done && st_q.ie && (st_q.lvl != 3'd0);

    // R1: an acknowledge always answers a strobe of the previous cycle
    p_ack_follows_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_sel));
    // R2: a non-privileged access under restriction is never acknowledged
    p_priv_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && cfg_super_only && !bus_super) |=> !bus_ack);
    // R9: a request is only raised while a result waits
    p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (done && irq_level != 3'd0));
    // R6: reading the low byte clears done
    p_lo_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(conv_busy == 1'b0 && $past(conv_busy) && inflight)) |=> !done);
endmodule

// File: tb/adc_card_ctrl_bench.sv
module adc_card_ctrl_bench;
    localparam int CONV_CYCLES = 20;
    localparam int TRIG_MIN    = 4;
    localparam logic [5:0] BASE = 6'h0D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_super = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        cfg_super_only = 1'b0, cfg_twos = 1'b0;
    logic        bus_ack;
    logic [7:0]  bus_rdata;
    logic        trig_n = 1'b1;
    logic        conv_start;
    logic        conv_busy = 1'b0;
    logic [11:0] conv_data = '0;
    logic [7:0]  conv_chan_gain;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;
    logic        led_green, led_red;

    int checks = 0;
    int failures = 0;
    int starts = 0;
    logic [11:0] next_sample = '0;
    logic [11:0] held_sample = '0;
    int busy_cnt = 0;
    logic [11:0] exp_q[$];

    always #4 clk = ~clk;

    adc_card_ctrl #(.TRIG_MIN_CYC(TRIG_MIN)) u_adc_card_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_super(bus_super),
        .base_sel(BASE), .cfg_super_only(cfg_super_only), .cfg_twos(cfg_twos),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .trig_n(trig_n),
        .conv_start(conv_start), .conv_busy(conv_busy), .conv_data(conv_data),
        .conv_chan_gain(conv_chan_gain), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector),
        .led_green(led_green), .led_red(led_red)
    );

    // converter model
    always @(posedge clk) begin
        if (conv_start && !conv_busy) begin
            conv_busy   <= 1'b1;
            busy_cnt    <= CONV_CYCLES;
            held_sample <= next_sample;
        end else if (conv_busy) begin
            if (busy_cnt == 1) begin
                conv_busy <= 1'b0;
                conv_data <= held_sample;
            end
            busy_cnt <= busy_cnt - 1;
        end
    end

    // start monitor
    always @(negedge clk) if (conv_start) starts++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_acc(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                           output logic [7:0] rd, output logic ack);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        ack = bus_ack;
        rd  = bus_rdata;
    endtask

    function automatic logic [15:0] addr_of(input logic [9:0] ofs);
        return {BASE, ofs};
    endfunction

    task automatic wr_reg(input logic [9:0] ofs, input logic [7:0] wd);
        logic [7:0] rd; logic ack;
        bus_acc(1'b1, addr_of(ofs), wd, rd, ack);
    endtask

    task automatic rd_reg(input logic [9:0] ofs, output logic [7:0] rd);
        logic ack;
        bus_acc(1'b0, addr_of(ofs), 8'h00, rd, ack);
    endtask

    task automatic wait_done();
        logic [7:0] st;
        for (int i = 0; i < 200; i++) begin
            rd_reg(10'h081, st);
            if (st[7]) return;
        end
        check(1'b0, "R6 done never set", 0, 1);
    endtask

    // scoreboard pop: read bytes and compare with the expected code
    task automatic read_result(input string req);
        logic [7:0] hi, lo;
        logic [11:0] raw, v;
        logic [15:0] expw;
        raw = exp_q.pop_front();
        v = raw;
        if (cfg_twos) v[11] = ~raw[11];
        expw = cfg_twos ? {{4{v[11]}}, v} : {4'h0, v};
        rd_reg(10'h086, hi);
        rd_reg(10'h087, lo);
        check(hi == expw[15:8], {req, " high byte"}, hi, expw[15:8]);
        check(lo == expw[7:0],  {req, " low byte"},  lo, expw[7:0]);
    endtask

    task automatic rand_conv(input logic [11:0] sample, input logic [7:0] chan);
        next_sample = sample;
        exp_q.push_back(sample);
        wr_reg(10'h085, chan);
        wait_done();
    endtask

    task automatic trig_pulse(input int low_cyc);
        @(negedge clk); trig_n = 1'b0;
        repeat (low_cyc) @(negedge clk);
        trig_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd; logic ack; int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check(!led_green && !led_red, "R3 reset leds", {led_red, led_green}, 0);
        check(!irq_req && !conv_start, "R3 reset outputs", {irq_req, conv_start}, 0);

        // R1 wrong window
        bus_acc(1'b1, {6'h0C, 10'h081}, 8'h0B, rd, ack);
        check(!ack, "R1 no ack outside window", ack, 0);
        rd_reg(10'h081, rd);
        check(rd == 8'h00, "R1 outside write ignored", rd, 0);

        // R2 privilege restriction
        cfg_super_only = 1'b1; bus_super = 1'b0;
        bus_acc(1'b1, addr_of(10'h081), 8'h03, rd, ack);
        check(!ack, "R2 no ack non-privileged", ack, 0);
        check(!led_green && !led_red, "R2 write ignored", {led_red, led_green}, 0);
        bus_super = 1'b1;
        bus_acc(1'b1, addr_of(10'h081), 8'h09, rd, ack);
        check(ack, "R1 ack in window", ack, 1);
        check(led_green && !led_red, "R3 led follow", {led_red, led_green}, 1);
        rd_reg(10'h081, rd);
        check(rd == 8'h09, "R3 control readback", rd, 8'h09);
        cfg_super_only = 1'b0;

        // R9 vector and level
        wr_reg(10'h083, 8'h5A);
        wr_reg(10'h084, 8'h03);
        check(irq_vector == 8'h5A, "R9 vector", irq_vector, 8'h5A);
        check(irq_level == 3'd3, "R9 level", irq_level, 3);

        // R4 random-channel start, R7 offset binary
        s0 = starts;
        rand_conv(12'h123, 8'h25);
        check(starts == s0 + 1, "R4 one start", starts - s0, 1);
        check(conv_chan_gain == 8'h25, "R4 channel out", conv_chan_gain, 8'h25);
        check(!irq_req, "R9 no irq with ie clear", irq_req, 0);
        read_result("R7");
        rd_reg(10'h081, rd);
        check(!rd[7], "R6 done cleared by low read", rd[7], 0);

        // R9 irq with enable
        wr_reg(10'h081, 8'h18);
        rand_conv(12'hFFF, 8'h01);
        check(irq_req, "R9 irq raised", irq_req, 1);
        read_result("R7 full scale");
        check(!irq_req, "R9 irq drops after read", irq_req, 0);

        // R8 two's complement
        cfg_twos = 1'b1;
        rand_conv(12'hFFF, 8'h02); read_result("R8 max");
        rand_conv(12'h000, 8'h03); read_result("R8 min");
        rand_conv(12'h800, 8'h04); read_result("R8 mid");
        cfg_twos = 1'b0;

        // R10 overrun
        s0 = starts;
        next_sample = 12'h456;
        exp_q.push_back(12'h456);
        wr_reg(10'h085, 8'h05);
        wr_reg(10'h085, 8'h06);
        rd_reg(10'h081, rd);
        check(rd[6], "R10 busy status", rd[6], 1);
        wait_done();
        check(starts == s0 + 1, "R10 second request ignored", starts - s0, 1);
        rd_reg(10'h081, rd);
        check(rd[5], "R10 overrun set", rd[5], 1);
        read_result("R10 first result kept");
        rd_reg(10'h081, rd);
        check(!rd[5], "R10 overrun cleared", rd[5], 0);

        // R11 channel write outside random mode
        wr_reg(10'h081, 8'h04);
        s0 = starts;
        wr_reg(10'h085, 8'h07);
        repeat (4) @(negedge clk);
        check(starts == s0, "R11 no start in trigger mode", starts - s0, 0);

        // R5 external trigger
        s0 = starts;
        trig_pulse(2);
        check(starts == s0, "R5 short pulse rejected", starts - s0, 0);
        next_sample = 12'h9AB;
        exp_q.push_back(12'h9AB);
        trig_pulse(8);
        check(starts == s0 + 1, "R5 long pulse starts", starts - s0, 1);
        wait_done();
        read_result("R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule